// File: doc/BRIEF.md
# Three-Wire Timekeeper Link Master

This block is a hardware engine that reads and writes the registers of a battery-backed timekeeping device over a slow bit-serial link. The link has four wires: an enable, a serial clock, a data line towards the device and a data line back from it. The device also exposes a ready flag. A host hands the block one request: a 3-bit register address, a 32-bit word and a read/write flag. The block runs the whole exchange on its own and answers with a one-cycle completion pulse, an error flag and, for reads, the 32-bit word it collected.

Each transaction starts with link bring-up. The master holds all link lines low and waits for the ready flag. Each wait attempt has a bounded number of polls. When an attempt runs out, the master asks the device to re-arm its ready flag and pauses. After a set number of such retries the bring-up counts as failed. Failed bring-ups are repeated after a pause. After a fixed number of consecutive failures the master pulses a reset request to the device, and after a fixed number of reset rounds it gives up with an error. Once the link is up, the master shifts out the frame, MSB first: the data then the address for a write, or just the address for a read. It then runs a direction phase. A read finishes by clocking in 32 bits. All delays are counted in system-clock cycles and set by parameters.

Top module: `rtc3w_master`

## Requirements
- R1: After reset, link_en, link_clk and link_dout are low, and rsp_done, rsp_err, req_reject, reset_req and ready_rearm are low.
- R2: During bring-up link_en stays low. It rises only two cycles after link_ready has been seen high, and never while the device is not ready.
- R3: A write shifts out 35 bits with link_en high: the 32 data bits MSB first, then the 3 address bits MSB first.
- R4: The direction phase is one clock pulse with link_en low. link_dout is 1 for a write and 0 for a read, and link_dout returns to 0 after the pulse.
- R5: A read shifts out the 3 address bits with link_en high, then the direction phase, then 32 clock pulses. link_din is sampled after each pulse's falling edge and assembled MSB first into rsp_rdata, which is valid while rsp_done is high.
- R6: Every bit pulse keeps link_clk low for HALF_CYC cycles and then high for HALF_CYC cycles. link_dout changes only while link_clk is low.
- R7: One ready-wait attempt polls link_ready for POLL_LIMIT cycles. An exhausted attempt pulses ready_rearm for one cycle and pauses PAUSE_CYC cycles. The exhaustion that follows READY_RETRIES re-arms fails the wait.
- R8: A failed bring-up is retried after PAUSE_CYC cycles. Every (INIT_RETRIES+1)-th consecutive failure pulses reset_req for one cycle. If RESET_ROUNDS resets have already been issued, that failure instead ends the transaction with rsp_done and rsp_err high and no link_clk pulse. With the defaults this means 3 resets and 48 re-arms.
- R9: A request (req_valid high) while a transaction is in progress is not queued. It raises req_reject for one cycle on the next cycle and does not disturb the running frame.
- R10: rsp_done lasts one cycle, and rsp_err is high only together with rsp_done. A request presented in the same cycle as rsp_done is accepted, not rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Device register address |
| req_wdata | input | DATA_W | Word to write |
| req_reject | output | 1 | Pulse: request refused because busy |
| rsp_done | output | 1 | Pulse: transaction finished |
| rsp_err | output | 1 | Bring-up gave up (valid with rsp_done) |
| rsp_rdata | output | DATA_W | Word read from the device |
| link_en | output | 1 | Link enable towards the device |
| link_clk | output | 1 | Serial clock towards the device |
| link_dout | output | 1 | Serial data towards the device |
| link_din | input | 1 | Serial data from the device |
| link_ready | input | 1 | Device ready flag |
| ready_rearm | output | 1 | Pulse: ask the device to re-arm its ready flag |
| reset_req | output | 1 | Pulse: ask the device to reset |

## Verification
Two functions can fall in the same cycle: the completion pulse of one transaction and the acceptance of the next request. The bench watches for rsp_done and raises req_valid in that very cycle. It then requires that req_reject stays low and that a complete, correctly formed second frame follows. A second case puts a request in the middle of a running write. The bench judges it by the one-cycle reject pulse and by checking that the write frame reaching the device model is unchanged.

// File: rtl/rtc3w_pkg.sv
package rtc3w_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAITRDY,
      ST_GAP,
      ST_SHIFT,
      ST_TURN,
      ST_CAPTURE
   } mst_state_t;

   typedef enum logic [1:0] {
      RW_IDLE,
      RW_POLL,
      RW_PAUSE
   } rw_state_t;

   // width of a counter that must hold values 0 .. n-1
   function automatic int unsigned cnt_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/rtc3w_edge_gen.sv
module rtc3w_edge_gen
   import rtc3w_pkg::*;
#(
   parameter int unsigned HALF_CYC = 250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic sclk,
   output logic done
);
   localparam int unsigned CW = cnt_w(2 * HALF_CYC);

   logic          active;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt    <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start && !active) begin
            active <= 1'b1;
            cnt    <= '0;
         end else if (active) begin
            if (cnt == CW'(2 * HALF_CYC - 1)) begin
               active <= 1'b0;
               done   <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   // low half first, then high half
   assign sclk = active && (cnt >= CW'(HALF_CYC));

endmodule

// File: rtl/rtc3w_ready_wait.sv
module rtc3w_ready_wait
   import rtc3w_pkg::*;
#(
   parameter int unsigned POLL_LIMIT    = 40000,
   parameter int unsigned READY_RETRIES = 3,
   parameter int unsigned PAUSE_CYC     = 5000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic ready,
   output logic ok,
   output logic fail,
   output logic rearm
);
   localparam int unsigned PW = cnt_w(POLL_LIMIT);
   localparam int unsigned RW = cnt_w(READY_RETRIES + 1);
   localparam int unsigned GW = cnt_w(PAUSE_CYC);

   rw_state_t     st;
   logic [PW-1:0] poll_cnt;
   logic [RW-1:0] retry_cnt;
   logic [GW-1:0] pause_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= RW_IDLE;
         poll_cnt  <= '0;
         retry_cnt <= '0;
         pause_cnt <= '0;
         ok        <= 1'b0;
         fail      <= 1'b0;
         rearm     <= 1'b0;
      end else begin
         ok    <= 1'b0;
         fail  <= 1'b0;
         rearm <= 1'b0;
         case (st)
            RW_IDLE: begin
               if (start) begin
                  st        <= RW_POLL;
                  poll_cnt  <= '0;
                  retry_cnt <= '0;
               end
            end
            RW_POLL: begin
               if (ready) begin
                  ok <= 1'b1;
                  st <= RW_IDLE;
               end else if (poll_cnt == PW'(POLL_LIMIT - 1)) begin
                  if (retry_cnt == RW'(READY_RETRIES)) begin
                     fail <= 1'b1;
                     st   <= RW_IDLE;
                  end else begin
                     retry_cnt <= retry_cnt + 1'b1;
                     rearm     <= 1'b1;
                     pause_cnt <= '0;
                     st        <= RW_PAUSE;
                  end
               end else begin
                  poll_cnt <= poll_cnt + 1'b1;
               end
            end
            RW_PAUSE: begin
               if (pause_cnt == GW'(PAUSE_CYC - 1)) begin
                  poll_cnt <= '0;
                  st       <= RW_POLL;
               end else begin
                  pause_cnt <= pause_cnt + 1'b1;
               end
            end
            default: st <= RW_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/rtc3w_master.sv
module rtc3w_master
   import rtc3w_pkg::*;
#(
   parameter int unsigned ADDR_W        = 3,
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned HALF_CYC      = 250,
   parameter int unsigned POLL_LIMIT    = 40000,
   parameter int unsigned READY_RETRIES = 3,
   parameter int unsigned PAUSE_CYC     = 5000,
   parameter int unsigned INIT_RETRIES  = 3,
   parameter int unsigned RESET_ROUNDS  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_reject,
   output logic              rsp_done,
   output logic              rsp_err,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              link_en,
   output logic              link_clk,
   output logic              link_dout,
   input  logic              link_din,
   input  logic              link_ready,
   output logic              ready_rearm,
   output logic              reset_req
);
   localparam int unsigned FRAME_W = DATA_W + ADDR_W;
   localparam int unsigned BW      = cnt_w(FRAME_W + 1);
   localparam int unsigned FW      = cnt_w(INIT_RETRIES + 1);
   localparam int unsigned NW      = cnt_w(RESET_ROUNDS + 1);
   localparam int unsigned GW      = cnt_w(PAUSE_CYC);

   mst_state_t         state;
   logic [FRAME_W-1:0] tx_sr;
   logic [DATA_W-1:0]  rx_sr;
   logic [BW-1:0]      bits_left;
   logic [FW-1:0]      fail_cnt;
   logic [NW-1:0]      round_cnt;
   logic [GW-1:0]      gap_cnt;
   logic               is_wr;
   logic               en_q;
   logic               dout_q;
   logic               pg_start;
   logic               pg_done;
   logic               rw_start;
   logic               rw_ok;
   logic               rw_fail;

   rtc3w_edge_gen #(
      .HALF_CYC(HALF_CYC)
   ) u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .start(pg_start),
      .sclk (link_clk),
      .done (pg_done)
   );

   rtc3w_ready_wait #(
      .POLL_LIMIT   (POLL_LIMIT),
      .READY_RETRIES(READY_RETRIES),
      .PAUSE_CYC    (PAUSE_CYC)
   ) u_rdy (
      .clk  (clk),
      .rst_n(rst_n),
      .start(rw_start),
      .ready(link_ready),
      .ok   (rw_ok),
      .fail (rw_fail),
      .rearm(ready_rearm)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         tx_sr      <= '0;
         rx_sr      <= '0;
         bits_left  <= '0;
         fail_cnt   <= '0;
         round_cnt  <= '0;
         gap_cnt    <= '0;
         is_wr      <= 1'b0;
         en_q       <= 1'b0;
         dout_q     <= 1'b0;
         pg_start   <= 1'b0;
         rw_start   <= 1'b0;
         rsp_done   <= 1'b0;
         rsp_err    <= 1'b0;
         reset_req  <= 1'b0;
         req_reject <= 1'b0;
      end else begin
         pg_start   <= 1'b0;
         rw_start   <= 1'b0;
         rsp_done   <= 1'b0;
         rsp_err    <= 1'b0;
         reset_req  <= 1'b0;
         req_reject <= req_valid && (state != ST_IDLE);
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  is_wr     <= req_write;
                  tx_sr     <= req_write ? {req_wdata, req_addr}
                                         : {req_addr, {DATA_W{1'b0}}};
                  bits_left <= req_write ? BW'(FRAME_W) : BW'(ADDR_W);
                  fail_cnt  <= '0;
                  round_cnt <= '0;
                  en_q      <= 1'b0;
                  dout_q    <= 1'b0;
                  rw_start  <= 1'b1;
                  state     <= ST_WAITRDY;
               end
            end
            ST_WAITRDY: begin
               if (rw_ok) begin
                  en_q     <= 1'b1;
                  dout_q   <= tx_sr[FRAME_W-1];
                  pg_start <= 1'b1;
                  state    <= ST_SHIFT;
               end else if (rw_fail) begin
                  gap_cnt <= '0;
                  if (fail_cnt == FW'(INIT_RETRIES)) begin
                     fail_cnt <= '0;
                     if (round_cnt == NW'(RESET_ROUNDS)) begin
                        rsp_done <= 1'b1;
                        rsp_err  <= 1'b1;
                        state    <= ST_IDLE;
                     end else begin
                        round_cnt <= round_cnt + 1'b1;
                        reset_req <= 1'b1;
                        state     <= ST_GAP;
                     end
                  end else begin
                     fail_cnt <= fail_cnt + 1'b1;
                     state    <= ST_GAP;
                  end
               end
            end
            ST_GAP: begin
               if (gap_cnt == GW'(PAUSE_CYC - 1)) begin
                  rw_start <= 1'b1;
                  state    <= ST_WAITRDY;
               end else begin
                  gap_cnt <= gap_cnt + 1'b1;
               end
            end
            ST_SHIFT: begin
               if (pg_done) begin
                  pg_start <= 1'b1;
                  if (bits_left == BW'(1)) begin
                     en_q   <= 1'b0;
                     dout_q <= is_wr;
                     state  <= ST_TURN;
                  end else begin
                     tx_sr     <= tx_sr << 1;
                     dout_q    <= tx_sr[FRAME_W-2];
                     bits_left <= bits_left - 1'b1;
                  end
               end
            end
            ST_TURN: begin
               if (pg_done) begin
                  dout_q <= 1'b0;
                  if (is_wr) begin
                     rsp_done <= 1'b1;
                     state    <= ST_IDLE;
                  end else begin
                     bits_left <= BW'(DATA_W);
                     pg_start  <= 1'b1;
                     state     <= ST_CAPTURE;
                  end
               end
            end
            ST_CAPTURE: begin
               if (pg_done) begin
                  rx_sr <= {rx_sr[DATA_W-2:0], link_din};
                  if (bits_left == BW'(1)) begin
                     rsp_done <= 1'b1;
                     state    <= ST_IDLE;
                  end else begin
                     bits_left <= bits_left - 1'b1;
                     pg_start  <= 1'b1;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign link_en   = en_q;
   assign link_dout = dout_q;
   assign rsp_rdata = rx_sr;

endmodule

// File: rtl/rtc3w_master_chk.sv
module rtc3w_master_chk (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic req_reject,
   input logic rsp_done,
   input logic rsp_err,
   input logic link_en,
   input logic link_clk,
   input logic link_dout,
   input logic link_ready,
   input logic ready_rearm,
   input logic reset_req
);
   // R2
   en_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_en) |-> $past(link_ready, 2));

   // R6
   dout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(link_dout) |-> (!link_clk && !$past(link_clk)));

   // R7
   rearm_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready_rearm |=> !ready_rearm);

   // R8
   reset_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |-> (!link_en && !link_clk));

   // R9
   reject_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_reject |-> $past(req_valid));

   // R10
   err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> rsp_done);

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

endmodule

bind rtc3w_master rtc3w_master_chk u_chk (.*);

// File: tb/rtc3w_master_tb.sv
`timescale 1ns/1ps
module rtc3w_master_tb;
   localparam int HALF = 2;
   localparam int POLL = 4;
   localparam int RRET = 3;
   localparam int PAUS = 3;
   localparam int IRET = 3;
   localparam int RRND = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [2:0]  req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        req_reject, rsp_done, rsp_err;
   logic [31:0] rsp_rdata;
   logic        link_en, link_clk, link_dout;
   logic        link_din = 1'b0;
   logic        link_ready = 1'b1;
   logic        ready_rearm, reset_req;

   int n_chk = 0;
   int n_err = 0;

   always #10 clk = ~clk;

   rtc3w_master #(
      .HALF_CYC(HALF), .POLL_LIMIT(POLL), .READY_RETRIES(RRET),
      .PAUSE_CYC(PAUS), .INIT_RETRIES(IRET), .RESET_ROUNDS(RRND)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_reject(req_reject),
      .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .link_en(link_en), .link_clk(link_clk), .link_dout(link_dout),
      .link_din(link_din), .link_ready(link_ready),
      .ready_rearm(ready_rearm), .reset_req(reset_req)
   );

   // device model
   logic [63:0] cap;
   int          ncap, enhi, rd_k;
   logic        turn_seen, rd_mode;
   logic [2:0]  rd_addr;
   logic [31:0] smem [0:7];

   task automatic clear_model();
      cap = '0; ncap = 0; enhi = 0; rd_k = 0;
      turn_seen = 1'b0; rd_mode = 1'b0; rd_addr = '0;
   endtask

   always @(posedge link_clk) begin
      cap = {cap[62:0], link_dout};
      ncap++;
      if (link_en) enhi++;
      else if (!turn_seen) begin
         turn_seen = 1'b1;
         if (link_dout) smem[cap[3:1]] = cap[35:4];
         else begin
            rd_mode = 1'b1;
            rd_addr = cap[3:1];
            rd_k    = 0;
         end
      end else if (rd_mode && rd_k < 32) begin
         link_din = smem[rd_addr][31-rd_k];
         rd_k++;
      end
   end

   // monitors sampled between edges
   int hi_run = 0, bad_w = 0, n_rearm = 0, n_rst = 0, n_rej = 0, en_nr = 0;
   always @(negedge clk) begin
      if (link_clk) hi_run++;
      else if (hi_run != 0) begin
         if (hi_run != HALF) bad_w++;
         hi_run = 0;
      end
      if (ready_rearm) n_rearm++;
      if (reset_req) n_rst++;
      if (req_reject) n_rej++;
      if (link_en && !link_ready) en_nr++;
   end

   task automatic check(input bit ok, input string req,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic issue(input logic wr, input logic [2:0] a, input logic [31:0] d);
      clear_model();
      req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_done(output logic [31:0] rd, output logic er);
      int t = 0;
      while (!rsp_done && t < 20000) begin
         @(negedge clk);
         t++;
      end
      check(rsp_done, "R10 completion", {63'd0, rsp_done}, 64'd1);
      rd = rsp_rdata; er = rsp_err;
      @(negedge clk);
      check(!rsp_done, "R10 done one cycle", {63'd0, rsp_done}, 64'd0);
   endtask

   task automatic check_frame(input logic wr, input logic [2:0] a, input logic [31:0] d);
      logic [35:0] ef;
      ef = wr ? {d, a, 1'b1} : {a, 1'b0, 32'd0};
      check(ncap == 36, wr ? "R3 write pulse count" : "R5 read pulse count", 64'(ncap), 64'd36);
      check(cap[35:0] == ef, wr ? "R3 R4 write frame" : "R4 R5 read frame", {28'd0, cap[35:0]}, {28'd0, ef});
      check(enhi == (wr ? 35 : 3), "R4 enable low only in direction phase", 64'(enhi), wr ? 64'd35 : 64'd3);
   endtask

   // {write, addr, data}
   localparam logic [35:0] VEC [0:7] = '{
      {1'b1, 3'd5, 32'hA5C3_0F91},
      {1'b1, 3'd0, 32'hFFFF_FFFF},
      {1'b1, 3'd7, 32'h0000_0001},
      {1'b0, 3'd5, 32'hA5C3_0F91},
      {1'b0, 3'd0, 32'hFFFF_FFFF},
      {1'b0, 3'd7, 32'h0000_0001},
      {1'b1, 3'd2, 32'h8000_0000},
      {1'b0, 3'd2, 32'h8000_0000}
   };

   initial begin
      #(20 * 150000);
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      logic        er;
      for (int i = 0; i < 8; i++) smem[i] = '0;
      clear_model();
      repeat (3) @(negedge clk);
      // R1 reset state
      check({link_en, link_clk, link_dout, rsp_done, rsp_err, req_reject, reset_req, ready_rearm} == 8'd0,
            "R1 reset outputs",
            {56'd0, link_en, link_clk, link_dout, rsp_done, rsp_err, req_reject, reset_req, ready_rearm}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < 8; v++) begin
         issue(VEC[v][35], VEC[v][34:32], VEC[v][31:0]);
         wait_done(rd, er);
         check(!er, "R10 no error", {63'd0, er}, 64'd0);
         check_frame(VEC[v][35], VEC[v][34:32], VEC[v][31:0]);
         if (!VEC[v][35])
            check(rd == VEC[v][31:0], "R5 read data", {32'd0, rd}, {32'd0, VEC[v][31:0]});
      end
      check(bad_w == 0, "R6 clock high width", 64'(bad_w), 64'd0);

      // R9 request during a running write
      n_rej = 0;
      issue(1'b1, 3'd3, 32'h1234_5678);
      repeat (10) @(negedge clk);
      req_write = 1'b0; req_addr = 3'd6; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check(req_reject, "R9 reject pulse", {63'd0, req_reject}, 64'd1);
      @(negedge clk);
      check(!req_reject, "R9 reject one cycle", {63'd0, req_reject}, 64'd0);
      req_addr = 3'd3; req_wdata = 32'h1234_5678;
      wait_done(rd, er);
      check_frame(1'b1, 3'd3, 32'h1234_5678);
      check(n_rej == 1, "R9 reject count", 64'(n_rej), 64'd1);

      // R10 request in the completion cycle
      issue(1'b0, 3'd3, 32'd0);
      while (!rsp_done) @(negedge clk);
      rd = rsp_rdata;
      check(rd == 32'h1234_5678, "R5 R9 read after rejected request", {32'd0, rd}, 64'h1234_5678);
      n_rej = 0;
      clear_model();
      req_write = 1'b1; req_addr = 3'd1; req_wdata = 32'h0F0F_5A5A; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      check(n_rej == 0, "R10 request in done cycle accepted", 64'(n_rej), 64'd0);
      wait_done(rd, er);
      check_frame(1'b1, 3'd1, 32'h0F0F_5A5A);

      // R2 R7 late ready
      link_ready = 1'b0; n_rearm = 0; n_rst = 0; en_nr = 0;
      issue(1'b1, 3'd4, 32'hCAFE_0042);
      repeat (10) @(negedge clk);
      check(en_nr == 0 && !link_en, "R2 enable low while not ready", 64'(en_nr), 64'd0);
      link_ready = 1'b1;
      wait_done(rd, er);
      check(!er, "R7 late ready no error", {63'd0, er}, 64'd0);
      check(n_rearm >= 1 && n_rearm <= RRET, "R7 rearm issued", 64'(n_rearm), 64'd1);
      check(n_rst == 0, "R8 no reset on recovered wait", 64'(n_rst), 64'd0);
      check_frame(1'b1, 3'd4, 32'hCAFE_0042);

      // R8 device never ready
      link_ready = 1'b0; n_rearm = 0; n_rst = 0; en_nr = 0;
      issue(1'b0, 3'd4, 32'd0);
      wait_done(rd, er);
      check(er, "R8 error flag", {63'd0, er}, 64'd1);
      check(n_rst == RRND, "R8 reset requests", 64'(n_rst), 64'(RRND));
      check(n_rearm == (IRET + 1) * (RRND + 1) * RRET, "R7 R8 rearm total",
            64'(n_rearm), 64'((IRET + 1) * (RRND + 1) * RRET));
      check(ncap == 0 && en_nr == 0, "R2 R8 no link activity", 64'(ncap), 64'd0);
      link_ready = 1'b1;
      check(bad_w == 0, "R6 clock high width", 64'(bad_w), 64'd0);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule